// File: doc/BRIEF.md
# Control loop parameter commit handshake

This block lets a host change the settings of a running control loop without the loop ever seeing a half-updated set. The host writes four shadow inputs: an 18-bit two's-complement setpoint, a proportional and an integral coefficient (64-bit two's-complement fixed point, 21 integer bits) and a 16-bit unsigned delay between iterations. It then raises a change request. The block copies all four shadow values into the working outputs in a single clock cycle, at a point where the loop says it sits between iterations. It then raises an acknowledge.

The request is edge-triggered. Each rising edge allows at most one commit. The acknowledge follows the request level, so the host sees the commit and then lowers the request to close the exchange. A request that falls before the commit is dropped. The block also registers a run input into an in-loop status flag. A loop that is not running is always treated as being at a safe point, so a commit then needs no idle strobe.

Top module: `clp_param_sync`

## Requirements
- R1: After reset, `chg_ack_o`, `in_loop_o` and all four working outputs are zero.
- R2: A rising edge of `chg_req_i` seen at a safe clock edge copies all four shadow inputs into the working outputs at that edge, and `chg_ack_o` is high from that edge on. A request that is already high when reset is released counts as a rising edge on the first edge after reset.
- R3: While the loop runs (`in_loop_o` = 1), a request waits with no effect until a clock edge where `loop_idle_i` = 1. The commit happens at that edge.
- R4: If `chg_req_i` falls before the commit, nothing is applied and `chg_ack_o` stays low, even if a safe point comes later.
- R5: `chg_ack_o` is high only in cycles that follow a clock edge at which `chg_req_i` was high.
- R6: While `chg_ack_o` is high, and whenever no commit takes place, the working outputs hold their value regardless of the shadow inputs.
- R7: `chg_ack_o` goes low at the first clock edge where `chg_req_i` is sampled low. A further commit needs a new rising edge of the request.
- R8: `in_loop_o` equals `run_i` as sampled at the previous clock edge.
- R9: While `in_loop_o` is low, every clock edge is a safe point, whatever the value of `loop_idle_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Loop run enable |
| loop_idle_i | input | 1 | Loop is between iterations (safe-point strobe) |
| chg_req_i | input | 1 | Host parameter change request |
| setpt_sh_i | input | 18 | Shadow setpoint |
| kp_sh_i | input | 64 | Shadow proportional coefficient |
| ki_sh_i | input | 64 | Shadow integral coefficient |
| delay_sh_i | input | 16 | Shadow inter-iteration delay |
| chg_ack_o | output | 1 | Change applied acknowledge |
| in_loop_o | output | 1 | Loop running status |
| setpt_o | output | 18 | Working setpoint |
| kp_o | output | 64 | Working proportional coefficient |
| ki_o | output | 64 | Working integral coefficient |
| delay_o | output | 16 | Working delay |

## Verification
On every cycle the assertions check four things. The acknowledge depends on the request, and it releases one cycle after the request falls. A commit happens only while the request is high, and never while an acknowledge is still standing. When the acknowledge rises, all four working fields change together, and they hold whenever no load happens. A stopped loop is always treated as safe. Some behaviour only the bench scenarios can show: a request that waits across several cycles of a running loop, a request withdrawn before a later idle strobe, shadow changes during an acknowledge, and a second commit that needs a fresh rising edge.

// File: rtl/clp_pkg.sv
package clp_pkg;

   // Handshake phases of the parameter commit exchange
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_WAIT = 2'd1,
      HS_HOLD = 2'd2
   } hs_state_e;

endpackage

// File: rtl/clp_req_edge.sv
module clp_req_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic rise_o
);

   logic req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_i;
   end

   assign rise_o = req_i & ~req_q;

endmodule

// File: rtl/clp_safe_gen.sv
module clp_safe_gen #(
   parameter bit STOPPED_IS_SAFE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic idle_i,
   output logic in_loop_o,
   output logic safe_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) in_loop_o <= 1'b0;
      else        in_loop_o <= run_i;
   end

   assert_inloop_on_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      run_i |=> in_loop_o);
   assert_inloop_off_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !in_loop_o);

   generate
      if (STOPPED_IS_SAFE) begin : g_stop_safe
         assign safe_o = idle_i | ~in_loop_o;
         assert_stopped_safe_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            !in_loop_o |-> safe_o);
      end else begin : g_strobe_only
         assign safe_o = idle_i;
      end
   endgenerate

endmodule

// File: rtl/clp_hs_fsm.sv
module clp_hs_fsm
   import clp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic rise_i,
   input  logic safe_i,
   output logic commit_o,
   output logic ack_o
);

   hs_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= HS_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      commit_o = 1'b0;
      unique case (state_q)
         HS_IDLE: begin
            if (rise_i) begin
               if (safe_i) begin
                  commit_o = 1'b1;
                  state_d  = HS_HOLD;
               end else begin
                  state_d  = HS_WAIT;
               end
            end
         end
         HS_WAIT: begin
            if (!req_i) begin
               state_d = HS_IDLE;
            end else if (safe_i) begin
               commit_o = 1'b1;
               state_d  = HS_HOLD;
            end
         end
         HS_HOLD: begin
            if (!req_i) state_d = HS_IDLE;
         end
         default: state_d = HS_IDLE;
      endcase
   end

   assign ack_o = (state_q == HS_HOLD);

   assert_ack_needs_req_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(req_i));
   assert_ack_release_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && !req_i) |=> !ack_o);
   assert_no_recommit_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !commit_o);
   assert_commit_needs_req_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> req_i);

endmodule

// File: rtl/clp_field_reg.sv
module clp_field_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("clp_field_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

   assert_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));

endmodule

// File: rtl/clp_param_sync.sv
module clp_param_sync #(
   parameter int SETPT_W         = 18,
   parameter int COEF_W          = 64,
   parameter int COEF_INT_W      = 21,
   parameter int DELAY_W         = 16,
   parameter bit STOPPED_IS_SAFE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               loop_idle_i,
   input  logic               chg_req_i,
   input  logic [SETPT_W-1:0] setpt_sh_i,
   input  logic [COEF_W-1:0]  kp_sh_i,
   input  logic [COEF_W-1:0]  ki_sh_i,
   input  logic [DELAY_W-1:0] delay_sh_i,
   output logic               chg_ack_o,
   output logic               in_loop_o,
   output logic [SETPT_W-1:0] setpt_o,
   output logic [COEF_W-1:0]  kp_o,
   output logic [COEF_W-1:0]  ki_o,
   output logic [DELAY_W-1:0] delay_o
);

   localparam int COEF_FRAC_W = COEF_W - COEF_INT_W;

   generate
      if (SETPT_W < 2) begin : g_bad_setpt
         $error("clp_param_sync: signed setpoint needs at least 2 bits");
      end
      if (COEF_INT_W < 1 || COEF_FRAC_W < 1) begin : g_bad_coef
         $error("clp_param_sync: coefficient needs integer and fraction bits");
      end
      if (DELAY_W < 1) begin : g_bad_delay
         $error("clp_param_sync: delay width must be positive");
      end
   endgenerate

   logic req_rise;
   logic safe_pt;
   logic commit;

   clp_req_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (chg_req_i),
      .rise_o (req_rise)
   );

   clp_safe_gen #(.STOPPED_IS_SAFE(STOPPED_IS_SAFE)) u_safe (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_i),
      .idle_i    (loop_idle_i),
      .in_loop_o (in_loop_o),
      .safe_o    (safe_pt)
   );

   clp_hs_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (chg_req_i),
      .rise_i   (req_rise),
      .safe_i   (safe_pt),
      .commit_o (commit),
      .ack_o    (chg_ack_o)
   );

   clp_field_reg #(.W(SETPT_W)) u_setpt (
      .clk(clk), .rst_n(rst_n), .load_i(commit), .d_i(setpt_sh_i), .q_o(setpt_o));
   clp_field_reg #(.W(COEF_W)) u_kp (
      .clk(clk), .rst_n(rst_n), .load_i(commit), .d_i(kp_sh_i), .q_o(kp_o));
   clp_field_reg #(.W(COEF_W)) u_ki (
      .clk(clk), .rst_n(rst_n), .load_i(commit), .d_i(ki_sh_i), .q_o(ki_o));
   clp_field_reg #(.W(DELAY_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .load_i(commit), .d_i(delay_sh_i), .q_o(delay_o));

   assert_all_fields_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_ack_o) |-> (setpt_o == $past(setpt_sh_i) && kp_o == $past(kp_sh_i) &&
                            ki_o == $past(ki_sh_i) && delay_o == $past(delay_sh_i)));
   assert_frozen_in_ack_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (chg_ack_o && $past(chg_ack_o)) |-> ($stable(setpt_o) && $stable(kp_o) &&
                                           $stable(ki_o) && $stable(delay_o)));

endmodule

// File: tb/clp_param_sync_bench.sv
module clp_param_sync_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0;
   logic        loop_idle_i = 1'b0;
   logic        chg_req_i = 1'b0;
   logic [17:0] setpt_sh_i = '0;
   logic [63:0] kp_sh_i = '0;
   logic [63:0] ki_sh_i = '0;
   logic [15:0] delay_sh_i = '0;
   logic        chg_ack_o, in_loop_o;
   logic [17:0] setpt_o;
   logic [63:0] kp_o, ki_o;
   logic [15:0] delay_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   clp_param_sync u_clp_param_sync (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .loop_idle_i(loop_idle_i),
      .chg_req_i(chg_req_i), .setpt_sh_i(setpt_sh_i), .kp_sh_i(kp_sh_i),
      .ki_sh_i(ki_sh_i), .delay_sh_i(delay_sh_i), .chg_ack_o(chg_ack_o),
      .in_loop_o(in_loop_o), .setpt_o(setpt_o), .kp_o(kp_o), .ki_o(ki_o),
      .delay_o(delay_o));

   // Behavioural reference: phase 0 = no request, 1 = waiting, 2 = acknowledged
   int          m_phase = 0;
   bit          m_req_prev = 1'b0;
   bit          m_inloop = 1'b0;
   logic [17:0] m_sp = '0;
   logic [63:0] m_kp = '0, m_ki = '0;
   logic [15:0] m_dly = '0;

   always @(posedge clk) begin
      bit edge_seen, at_safe, take;
      if (!rst_n) begin
         m_phase = 0; m_req_prev = 0; m_inloop = 0;
         m_sp = '0; m_kp = '0; m_ki = '0; m_dly = '0;
      end else begin
         edge_seen = chg_req_i && !m_req_prev;
         at_safe   = loop_idle_i || !m_inloop;
         take      = 1'b0;
         if (m_phase == 0 && edge_seen) begin
            if (at_safe) begin take = 1'b1; m_phase = 2; end
            else m_phase = 1;
         end else if (m_phase == 1) begin
            if (!chg_req_i) m_phase = 0;
            else if (at_safe) begin take = 1'b1; m_phase = 2; end
         end else if (m_phase == 2 && !chg_req_i) begin
            m_phase = 0;
         end
         if (take) begin
            m_sp = setpt_sh_i; m_kp = kp_sh_i; m_ki = ki_sh_i; m_dly = delay_sh_i;
         end
         m_req_prev = chg_req_i;
         m_inloop   = run_i;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5 ack vs model", 64'(chg_ack_o), 64'(m_phase == 2));
         chk("R8 in_loop vs model", 64'(in_loop_o), 64'(m_inloop));
         chk("R2 setpt vs model", 64'(setpt_o), 64'(m_sp));
         chk("R2 kp vs model", kp_o, m_kp);
         chk("R2 ki vs model", ki_o, m_ki);
         chk("R2 delay vs model", 64'(delay_o), 64'(m_dly));
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_shadow(input logic [17:0] s, input logic [63:0] p,
                             input logic [63:0] q, input logic [15:0] d);
      setpt_sh_i = s; kp_sh_i = p; ki_sh_i = q; delay_sh_i = d;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      step(4);
      rst_n = 1'b1;
      step(1);
      // R1: reset values
      chk("R1 ack", 64'(chg_ack_o), 0);
      chk("R1 in_loop", 64'(in_loop_o), 0);
      chk("R1 setpt", 64'(setpt_o), 0);
      chk("R1 kp", kp_o, 0);
      chk("R1 delay", 64'(delay_o), 0);

      // R2, R9: stopped loop commits at once without idle strobe
      set_shadow(18'h2_0005, 64'hFFFF_FFFF_FFE0_0000, 64'h0000_0000_0020_0000, 16'd300);
      chg_req_i = 1'b1;
      step(1);
      chk("R2 ack after commit", 64'(chg_ack_o), 1);
      chk("R9 setpt committed while stopped", 64'(setpt_o), 64'h2_0005);
      chk("R2 kp committed", kp_o, 64'hFFFF_FFFF_FFE0_0000);
      chk("R2 ki committed", ki_o, 64'h0000_0000_0020_0000);
      chk("R2 delay committed", 64'(delay_o), 64'd300);

      // R6: shadow changes during acknowledge are ignored
      set_shadow(18'h0_1234, 64'h1, 64'h2, 16'd7);
      step(3);
      chk("R6 setpt held during ack", 64'(setpt_o), 64'h2_0005);
      chk("R6 kp held during ack", kp_o, 64'hFFFF_FFFF_FFE0_0000);

      // R7: ack falls at the edge where the request is seen low
      chg_req_i = 1'b0;
      step(1);
      chk("R7 ack released", 64'(chg_ack_o), 0);
      chk("R6 setpt held after release", 64'(setpt_o), 64'h2_0005);

      // R8, R3: running loop, request waits for idle strobe
      run_i = 1'b1; loop_idle_i = 1'b0;
      step(1);
      chk("R8 in_loop follows run", 64'(in_loop_o), 1);
      chg_req_i = 1'b1;
      step(3);
      chk("R3 no ack before idle", 64'(chg_ack_o), 0);
      chk("R3 setpt unchanged while waiting", 64'(setpt_o), 64'h2_0005);
      loop_idle_i = 1'b1;
      step(1);
      chk("R3 ack at idle strobe", 64'(chg_ack_o), 1);
      chk("R3 setpt committed at idle", 64'(setpt_o), 64'h0_1234);
      chk("R3 delay committed at idle", 64'(delay_o), 64'd7);
      step(2);
      chk("R7 no second commit while held", 64'(setpt_o), 64'h0_1234);
      loop_idle_i = 1'b0;
      chg_req_i = 1'b0;
      step(1);

      // R4: withdrawn request is ignored even when idle comes later
      set_shadow(18'h3_FFFF, 64'hAAAA, 64'hBBBB, 16'd9);
      chg_req_i = 1'b1;
      step(1);
      chg_req_i = 1'b0;
      step(1);
      loop_idle_i = 1'b1;
      step(2);
      chk("R4 ack stays low", 64'(chg_ack_o), 0);
      chk("R4 setpt not applied", 64'(setpt_o), 64'h0_1234);
      chk("R4 kp not applied", kp_o, 64'h1);

      // R7: new rising edge gives a new commit
      chg_req_i = 1'b1;
      step(1);
      chk("R7 fresh edge commits", 64'(setpt_o), 64'h3_FFFF);
      chk("R7 fresh edge ack", 64'(chg_ack_o), 1);
      run_i = 1'b0; loop_idle_i = 1'b0;
      step(1);
      chk("R8 in_loop drops", 64'(in_loop_o), 0);
      chg_req_i = 1'b0;
      step(1);
      set_shadow(18'h0_0042, 64'h5, 64'h6, 16'd1);
      chg_req_i = 1'b1;
      step(1);
      chk("R9 stopped commit without strobe", 64'(setpt_o), 64'h0_0042);
      chk("R5 ack with request", 64'(chg_ack_o), 1);
      chg_req_i = 1'b0;
      step(2);
      chk("R5 ack low without request", 64'(chg_ack_o), 0);
      summary();
   end

endmodule